// File: doc/BRIEF.md
# DRAM Strobe Sequence Cycle Decoder

This block is the control front end of an asynchronous DRAM device model built for a fast clock domain. It samples the active-low row strobe, column strobe, write enable and output enable through a two-stage synchroniser. It tracks the order in which these strobes change and works out what kind of cycle the host is running: a read, an early write, a read-modify-write, a refresh addressed by the row strobe alone, a refresh that uses an internal row counter, a hidden refresh, or self-refresh.

From that decision it produces the signals the storage array needs. These are single-cycle row and column latch pulses, a write pulse, a refresh pulse together with the refreshed row, and a data output enable. The output enable follows extended-data-out rules: read data stays driven after the column strobe rises, and the drivers turn off only once both strobes are high. The array itself sits outside the block.

Top module: `dram_strobe_decoder`

## Requirements
- R1: After reset, all pulse outputs, `dq_oe` and `self_active` are 0, `cyc_kind` is 0 (none), and the internal refresh row counter is 0.
- R2: A row strobe fall with the column strobe high gives one `row_le` pulse. The cycle ends when the row strobe rises, and that rise gives one `ref_stb` with `ref_row` equal to the address sampled at the fall. If the column strobe stayed high for the whole low period, `cyc_kind` becomes 4 and `dq_oe` never rises.
- R3: If the row strobe falls while the column strobe is already low, `cyc_kind` becomes 5 and one `ref_stb` is issued with `ref_row` equal to the counter value, after which the counter increments. WE and OE are ignored, `dq_oe` stays 0, and no latch or write pulse occurs.
- R4: A column strobe fall with WE high, inside an open row, is a read. `cyc_kind` becomes 1, one `col_le` pulse occurs, and `dq_oe` is 1 while OE is low.
- R5: A column strobe fall with WE low is an early write. `cyc_kind` becomes 2, one `col_le` and one `wr_stb` occur in the same cycle, and `dq_oe` stays 0.
- R6: If WE falls while a read's column strobe is still low, `cyc_kind` becomes 3 and one `wr_stb` occurs. `dq_oe` is 1 before WE falls and 0 while WE is low.
- R7: After a read, `dq_oe` stays 1 when only one of the two strobes has risen, and returns to 0 once both are high.
- R8: With OE high, `dq_oe` is 0 during a read. It becomes 1 within five clocks after OE goes low.
- R9: If the row strobe rises after a read while the column strobe is held low, and then falls again, this is a hidden refresh. `cyc_kind` becomes 6, one `ref_stb` carries the counter row and the counter increments, and `dq_oe` stays 1.
- R10: If the row strobe is held low for `SELF_ENTER_CYCLES` clocks in a counter-refresh cycle, `self_active` is set and `cyc_kind` becomes 7. After that, one `ref_stb` with the next counter row is issued every `SELF_INTERVAL` clocks and `dq_oe` is 0. A row strobe rise clears `self_active`.
- R11: Rows from the counter are consecutive and wrap modulo 2^`ROW_BITS` (4096 for the default of 12, 2048 for 11). After 2^`ROW_BITS` counter refreshes, every row has been issued once and the next row equals the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ROW_BITS | Multiplexed address, held stable around strobe edges |
| row_le | output | 1 | One-cycle row latch pulse |
| col_le | output | 1 | One-cycle column latch pulse |
| wr_stb | output | 1 | One-cycle array write pulse |
| ref_stb | output | 1 | One-cycle row refresh pulse |
| ref_row | output | ROW_BITS | Row refreshed, valid with `ref_stb` |
| dq_oe | output | 1 | Data output driver enable |
| cyc_kind | output | 3 | Last classified cycle: 0 none, 1 read, 2 early write, 3 read-modify-write, 4 row-only refresh, 5 counter refresh, 6 hidden refresh, 7 self-refresh |
| self_active | output | 1 | Self-refresh in progress |

## Verification
A wrong state in the cycle tracker shows up at the ports within about three clocks of the strobe change that exposed it. It appears as a wrong `cyc_kind` code, a missing or extra latch or write pulse, or a `dq_oe` that stays on or turns off at the wrong strobe. A counter fault is silent until the next counter-based refresh, where `ref_row` differs from the running model. The bench checks every refresh pulse against that model, so a skipped or repeated row is reported at the first pulse that shows it.

// File: rtl/dram_strobe_pkg.sv
package dram_strobe_pkg;

    typedef enum logic [2:0] {
        K_NONE    = 3'd0,
        K_READ    = 3'd1,
        K_EWRITE  = 3'd2,
        K_RMW     = 3'd3,
        K_RASONLY = 3'd4,
        K_CBR     = 3'd5,
        K_HIDDEN  = 3'd6,
        K_SELF    = 3'd7
    } cyc_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,    // both strobes high
        S_CASPRE,  // column strobe low first, no data
        S_ROW,     // row open, no column yet
        S_ACC,     // row open, column low
        S_PAGE,    // row open, column high after an access
        S_HOLD,    // row high, column low after an access
        S_CBR,     // counter refresh (plain or hidden)
        S_SELF     // self-refresh
    } fsm_state_e;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int           WIDTH   = 4,
    parameter int           STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[g] <= RST_VAL;
                else        pipe_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[g] <= RST_VAL;
                else        pipe_q[g] <= pipe_q[g-1];
            end
        end
    end

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/refresh_ctr.sv
module refresh_ctr #(
    parameter int ROW_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inc,
    output logic [ROW_BITS-1:0] row_o
);

    logic [ROW_BITS-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (inc) row_d = row_q + 1'b1;   // wraps at 2**ROW_BITS
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row_o = row_q;

    assert_ctr_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (row_q == ROW_BITS'($past(row_q) + 1'b1)));

    assert_ctr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(row_q));

endmodule

// File: rtl/cycle_fsm.sv
module cycle_fsm
    import dram_strobe_pkg::*;
#(
    parameter int ROW_BITS          = 12,
    parameter int SELF_ENTER_CYCLES = 10000,
    parameter int SELF_INTERVAL     = 1500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic [ROW_BITS-1:0] addr,
    input  logic [ROW_BITS-1:0] ctr_row,
    output logic                ctr_inc,
    output logic                row_le,
    output logic                col_le,
    output logic                wr_stb,
    output logic                ref_stb,
    output logic [ROW_BITS-1:0] ref_row,
    output logic                dq_oe,
    output logic [2:0]          kind,
    output logic                self_active
);

    localparam int TMR_MAX = (SELF_ENTER_CYCLES > SELF_INTERVAL) ? SELF_ENTER_CYCLES : SELF_INTERVAL;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [TMR_W-1:0] ENTER_LAST = TMR_W'(SELF_ENTER_CYCLES - 1);
    localparam logic [TMR_W-1:0] IVL_LAST   = TMR_W'(SELF_INTERVAL - 1);

    typedef struct packed {
        fsm_state_e          st;
        cyc_kind_e           kind;
        logic                valid;   // read data available for the bus
        logic [ROW_BITS-1:0] row;
        logic [TMR_W-1:0]    tmr;
        logic                row_le;
        logic                col_le;
        logic                wr;
        logic                rf;
        logic [ROW_BITS-1:0] ref_row;
        logic                dq_oe;
    } fsm_reg_t;

    fsm_reg_t r_d, r_q;
    logic     inc_d;

    always_comb begin
        r_d        = r_q;
        r_d.row_le = 1'b0;
        r_d.col_le = 1'b0;
        r_d.wr     = 1'b0;
        r_d.rf     = 1'b0;
        inc_d      = 1'b0;

        unique case (r_q.st)
            S_IDLE: begin
                r_d.valid = 1'b0;
                if (!ras_n) begin
                    r_d.st     = S_ROW;
                    r_d.row    = addr;
                    r_d.row_le = 1'b1;
                end else if (!cas_n) begin
                    r_d.st = S_CASPRE;
                end
            end
            S_CASPRE: begin
                if (!ras_n) begin
                    r_d.st      = S_CBR;
                    r_d.kind    = K_CBR;
                    r_d.valid   = 1'b0;
                    r_d.rf      = 1'b1;
                    r_d.ref_row = ctr_row;
                    r_d.tmr     = '0;
                    inc_d       = 1'b1;
                end else if (cas_n) begin
                    r_d.st = S_IDLE;
                end
            end
            S_ROW, S_PAGE: begin
                if (ras_n) begin
                    r_d.st      = S_IDLE;
                    r_d.valid   = 1'b0;
                    r_d.rf      = 1'b1;
                    r_d.ref_row = r_q.row;
                    if (r_q.st == S_ROW) r_d.kind = K_RASONLY;
                end else if (!cas_n) begin
                    r_d.st     = S_ACC;
                    r_d.col_le = 1'b1;
                    if (!we_n) begin
                        r_d.kind  = K_EWRITE;
                        r_d.wr    = 1'b1;
                        r_d.valid = 1'b0;
                    end else begin
                        r_d.kind  = K_READ;
                        r_d.valid = 1'b1;
                    end
                end
            end
            S_ACC: begin
                if (ras_n) begin
                    r_d.st      = S_HOLD;
                    r_d.rf      = 1'b1;
                    r_d.ref_row = r_q.row;
                end else if (cas_n) begin
                    r_d.st = S_PAGE;
                end else if (!we_n && r_q.kind == K_READ) begin
                    r_d.kind = K_RMW;
                    r_d.wr   = 1'b1;
                end
            end
            S_HOLD: begin
                if (cas_n) begin
                    r_d.st    = S_IDLE;
                    r_d.valid = 1'b0;
                end else if (!ras_n) begin
                    r_d.st      = S_CBR;
                    r_d.kind    = r_q.valid ? K_HIDDEN : K_CBR;
                    r_d.rf      = 1'b1;
                    r_d.ref_row = ctr_row;
                    r_d.tmr     = '0;
                    inc_d       = 1'b1;
                end
            end
            S_CBR: begin
                if (ras_n) begin
                    if (cas_n) begin
                        r_d.st    = S_IDLE;
                        r_d.valid = 1'b0;
                    end else begin
                        r_d.st = r_q.valid ? S_HOLD : S_CASPRE;
                    end
                end else if (r_q.tmr == ENTER_LAST) begin
                    r_d.st    = S_SELF;
                    r_d.kind  = K_SELF;
                    r_d.valid = 1'b0;
                    r_d.tmr   = '0;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            S_SELF: begin
                if (ras_n) begin
                    r_d.st  = cas_n ? S_IDLE : S_CASPRE;
                    r_d.tmr = '0;
                end else if (r_q.tmr == IVL_LAST) begin
                    r_d.tmr     = '0;
                    r_d.rf      = 1'b1;
                    r_d.ref_row = ctr_row;
                    inc_d       = 1'b1;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            default: r_d.st = S_IDLE;
        endcase

        // Drivers on only with data held, OE low and no write in progress.
        r_d.dq_oe = r_d.valid && !oe_n && we_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, kind: K_NONE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ctr_inc     = inc_d;
    assign row_le      = r_q.row_le;
    assign col_le      = r_q.col_le;
    assign wr_stb      = r_q.wr;
    assign ref_stb     = r_q.rf;
    assign ref_row     = r_q.ref_row;
    assign dq_oe       = r_q.dq_oe;
    assign kind        = r_q.kind;
    assign self_active = (r_q.st == S_SELF);

    assert_cbr_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_stb && kind == K_CBR) |-> !dq_oe);

    // Covers the write pulse of both early write and read-modify-write (R6).
    assert_write_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !dq_oe);

    assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({row_le, col_le}));

    assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> !dq_oe);

    assert_self_hiz_R10: assert property (@(posedge clk) disable iff (!rst_n)
        self_active |-> !dq_oe);

    assert_self_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (self_active && ras_n) |=> !self_active);

endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder #(
    parameter int ROW_BITS          = 12,
    parameter int SELF_ENTER_CYCLES = 10000,
    parameter int SELF_INTERVAL     = 1500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic [ROW_BITS-1:0] addr,
    output logic                row_le,
    output logic                col_le,
    output logic                wr_stb,
    output logic                ref_stb,
    output logic [ROW_BITS-1:0] ref_row,
    output logic                dq_oe,
    output logic [2:0]          cyc_kind,
    output logic                self_active
);

    localparam int SYNC_W = ROW_BITS + 4;

    logic [SYNC_W-1:0]   raw_in, sync_out;
    logic [ROW_BITS-1:0] ctr_row;
    logic                ctr_inc;

    assign raw_in = {addr, oe_n, we_n, cas_n, ras_n};

    strobe_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (2),
        .RST_VAL({{ROW_BITS{1'b0}}, 4'b1111})
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_in),
        .q    (sync_out)
    );

    refresh_ctr #(
        .ROW_BITS(ROW_BITS)
    ) i_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (ctr_inc),
        .row_o(ctr_row)
    );

    cycle_fsm #(
        .ROW_BITS         (ROW_BITS),
        .SELF_ENTER_CYCLES(SELF_ENTER_CYCLES),
        .SELF_INTERVAL    (SELF_INTERVAL)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ras_n      (sync_out[0]),
        .cas_n      (sync_out[1]),
        .we_n       (sync_out[2]),
        .oe_n       (sync_out[3]),
        .addr       (sync_out[SYNC_W-1:4]),
        .ctr_row    (ctr_row),
        .ctr_inc    (ctr_inc),
        .row_le     (row_le),
        .col_le     (col_le),
        .wr_stb     (wr_stb),
        .ref_stb    (ref_stb),
        .ref_row    (ref_row),
        .dq_oe      (dq_oe),
        .kind       (cyc_kind),
        .self_active(self_active)
    );

endmodule

// File: tb/test_dram_strobe_decoder.sv
module test_dram_strobe_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int ROW_BITS   = 12;
    localparam int ENTER      = 200;
    localparam int IVL        = 50;
    localparam int SETTLE     = 5;
    localparam int NVEC       = 10;

    typedef struct packed {
        logic [3:0]  op;
        logic [11:0] addr;
        logic [2:0]  kind;
        logic [1:0]  rle;
        logic [1:0]  cle;
        logic [1:0]  wr;
        logic [1:0]  rf;
        logic        oe_any;
    } vec_t;

    // op: 0 read, 1 early write, 2 rmw, 3 row-only refresh, 4 counter refresh,
    //     5 hidden refresh, 6 page read then write, 7 read with OE late
    localparam vec_t VEC [NVEC] = '{
        '{4'd0, 12'h123, 3'd1, 2'd1, 2'd1, 2'd0, 2'd1, 1'b1},
        '{4'd1, 12'hABC, 3'd2, 2'd1, 2'd1, 2'd1, 2'd1, 1'b0},
        '{4'd2, 12'h555, 3'd3, 2'd1, 2'd1, 2'd1, 2'd1, 1'b1},
        '{4'd3, 12'hFFF, 3'd4, 2'd1, 2'd0, 2'd0, 2'd1, 1'b0},
        '{4'd4, 12'h000, 3'd5, 2'd0, 2'd0, 2'd0, 2'd1, 1'b0},
        '{4'd5, 12'h0F0, 3'd6, 2'd1, 2'd1, 2'd0, 2'd2, 1'b1},
        '{4'd6, 12'h321, 3'd2, 2'd1, 2'd2, 2'd1, 2'd1, 1'b1},
        '{4'd7, 12'h0AA, 3'd1, 2'd1, 2'd1, 2'd0, 2'd1, 1'b1},
        '{4'd3, 12'h000, 3'd4, 2'd1, 2'd0, 2'd0, 2'd1, 1'b0},
        '{4'd4, 12'h000, 3'd5, 2'd0, 2'd0, 2'd0, 2'd1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
    logic [ROW_BITS-1:0] addr = '0;
    logic row_le, col_le, wr_stb, ref_stb, dq_oe, self_active;
    logic [ROW_BITS-1:0] ref_row;
    logic [2:0] cyc_kind;

    int n_chk = 0, n_err = 0;
    int n_rle = 0, n_cle = 0, n_wr = 0, n_ref = 0;
    logic oe_seen = 1'b0;
    logic ctr_mode = 1'b0;
    logic [ROW_BITS-1:0] exp_row = '0;
    logic [ROW_BITS-1:0] mdl_ctr = '0;
    logic [ROW_BITS-1:0] last_ref = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_strobe_decoder #(
        .ROW_BITS(ROW_BITS), .SELF_ENTER_CYCLES(ENTER), .SELF_INTERVAL(IVL)
    ) i_dram_strobe_decoder (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .row_le(row_le), .col_le(col_le),
        .wr_stb(wr_stb), .ref_stb(ref_stb), .ref_row(ref_row), .dq_oe(dq_oe),
        .cyc_kind(cyc_kind), .self_active(self_active)
    );

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Pulse counting and refresh row checking, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (row_le) n_rle++;
            if (col_le) n_cle++;
            if (wr_stb) n_wr++;
            if (dq_oe)  oe_seen = 1'b1;
            if (ref_stb) begin
                n_ref++;
                last_ref = ref_row;
                if (ctr_mode) begin
                    chk(ref_row == mdl_ctr, "R11 counter row", ref_row, mdl_ctr);
                    mdl_ctr = mdl_ctr + 1'b1;
                end else begin
                    chk(ref_row == exp_row, "R2 row refresh", ref_row, exp_row);
                end
            end
        end
    end

    task automatic op_read(input logic [ROW_BITS-1:0] a, input logic oe_late);
        addr = a; exp_row = a;
        ras_n = 1'b0; step(SETTLE);
        we_n = 1'b1; oe_n = oe_late; cas_n = 1'b0; step(SETTLE);
        if (oe_late) begin
            chk(dq_oe == 1'b0, "R8 OE high", dq_oe, 0);
            oe_n = 1'b0; step(SETTLE);
            chk(dq_oe == 1'b1, "R8 OE low", dq_oe, 1);
        end
        chk(dq_oe == 1'b1, "R4 read drive", dq_oe, 1);
        cas_n = 1'b1; step(SETTLE);
        chk(dq_oe == 1'b1, "R7 hold after CAS rise", dq_oe, 1);
        ras_n = 1'b1; step(SETTLE);
        chk(dq_oe == 1'b0, "R7 off after both high", dq_oe, 0);
    endtask

    task automatic op_ewrite(input logic [ROW_BITS-1:0] a);
        addr = a; exp_row = a;
        ras_n = 1'b0; step(SETTLE);
        we_n = 1'b0; cas_n = 1'b0; step(SETTLE);
        chk(dq_oe == 1'b0, "R5 early write hi-z", dq_oe, 0);
        cas_n = 1'b1; we_n = 1'b1; step(SETTLE);
        ras_n = 1'b1; step(SETTLE);
    endtask

    task automatic op_rmw(input logic [ROW_BITS-1:0] a);
        addr = a; exp_row = a;
        ras_n = 1'b0; step(SETTLE);
        cas_n = 1'b0; step(SETTLE);
        chk(dq_oe == 1'b1, "R6 data before write", dq_oe, 1);
        we_n = 1'b0; step(SETTLE);
        chk(dq_oe == 1'b0, "R6 off during write", dq_oe, 0);
        we_n = 1'b1; cas_n = 1'b1; step(SETTLE);
        ras_n = 1'b1; step(SETTLE);
    endtask

    task automatic op_rasonly(input logic [ROW_BITS-1:0] a);
        addr = a; exp_row = a;
        ras_n = 1'b0; step(SETTLE);
        ras_n = 1'b1; step(SETTLE);
    endtask

    task automatic op_cbr();
        ctr_mode = 1'b1;
        cas_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; step(SETTLE);
        ras_n = 1'b0; step(SETTLE);
        chk(dq_oe == 1'b0, "R3 CBR hi-z with OE and WE low", dq_oe, 0);
        ras_n = 1'b1; step(SETTLE);
        cas_n = 1'b1; we_n = 1'b1; step(SETTLE);
        ctr_mode = 1'b0;
    endtask

    task automatic op_hidden(input logic [ROW_BITS-1:0] a);
        addr = a; exp_row = a;
        ras_n = 1'b0; step(SETTLE);
        cas_n = 1'b0; step(SETTLE);
        chk(dq_oe == 1'b1, "R4 read drive", dq_oe, 1);
        ras_n = 1'b1; step(SETTLE);
        chk(dq_oe == 1'b1, "R7 hold after RAS rise", dq_oe, 1);
        ctr_mode = 1'b1;
        ras_n = 1'b0; step(SETTLE);
        chk(dq_oe == 1'b1, "R9 hidden keeps data", dq_oe, 1);
        chk(cyc_kind == 3'd6, "R9 hidden kind", cyc_kind, 6);
        ras_n = 1'b1; step(SETTLE);
        cas_n = 1'b1; step(SETTLE);
        chk(dq_oe == 1'b0, "R7 off after both high", dq_oe, 0);
        ctr_mode = 1'b0;
    endtask

    task automatic op_page(input logic [ROW_BITS-1:0] a);
        addr = a; exp_row = a;
        ras_n = 1'b0; step(SETTLE);
        cas_n = 1'b0; step(SETTLE);
        cas_n = 1'b1; step(SETTLE);
        chk(dq_oe == 1'b1, "R7 page hold", dq_oe, 1);
        we_n = 1'b0; cas_n = 1'b0; step(SETTLE);
        chk(dq_oe == 1'b0, "R5 page write hi-z", dq_oe, 0);
        cas_n = 1'b1; we_n = 1'b1; step(SETTLE);
        ras_n = 1'b1; step(SETTLE);
    endtask

    function automatic string op_tag(input logic [3:0] op);
        case (op)
            4'd0: return "R4";
            4'd1: return "R5";
            4'd2: return "R6";
            4'd3: return "R2";
            4'd4: return "R3";
            4'd5: return "R9";
            4'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(SETTLE);
        // R1: reset state
        chk(row_le == 0 && col_le == 0 && wr_stb == 0 && ref_stb == 0, "R1 pulses idle",
            {row_le, col_le, wr_stb, ref_stb}, 0);
        chk(dq_oe == 0, "R1 dq_oe", dq_oe, 0);
        chk(cyc_kind == 0, "R1 kind", cyc_kind, 0);
        chk(self_active == 0, "R1 self_active", self_active, 0);

        for (int i = 0; i < NVEC; i++) begin
            vec_t v = VEC[i];
            string t = op_tag(v.op);
            n_rle = 0; n_cle = 0; n_wr = 0; n_ref = 0; oe_seen = 1'b0;
            case (v.op)
                4'd0: op_read(v.addr, 1'b0);
                4'd1: op_ewrite(v.addr);
                4'd2: op_rmw(v.addr);
                4'd3: op_rasonly(v.addr);
                4'd4: op_cbr();
                4'd5: op_hidden(v.addr);
                4'd6: op_page(v.addr);
                default: op_read(v.addr, 1'b1);
            endcase
            step(SETTLE);
            chk(cyc_kind == v.kind, {t, " kind"}, cyc_kind, v.kind);
            chk(n_rle == v.rle, {t, " row latch count"}, n_rle, v.rle);
            chk(n_cle == v.cle, {t, " column latch count"}, n_cle, v.cle);
            chk(n_wr == v.wr, {t, " write count"}, n_wr, v.wr);
            chk(n_ref == v.rf, {t, " refresh count"}, n_ref, v.rf);
            chk(oe_seen == v.oe_any, {t, " output drive seen"}, oe_seen, v.oe_any);
            chk(dq_oe == 1'b0, {t, " idle hi-z"}, dq_oe, 0);
        end

        // R10: self-refresh entry, periodic refresh, exit
        ctr_mode = 1'b1;
        cas_n = 1'b0; step(SETTLE);
        ras_n = 1'b0; step(SETTLE);
        step(ENTER - 20);
        chk(self_active == 1'b0, "R10 not yet in self", self_active, 0);
        step(40);
        chk(self_active == 1'b1, "R10 self entered", self_active, 1);
        chk(cyc_kind == 3'd7, "R10 self kind", cyc_kind, 7);
        chk(dq_oe == 1'b0, "R10 self hi-z", dq_oe, 0);
        n_ref = 0;
        step(4 * IVL);
        chk(n_ref == 4, "R10 periodic refresh count", n_ref, 4);
        ras_n = 1'b1; step(SETTLE);
        chk(self_active == 1'b0, "R10 self exit", self_active, 0);
        cas_n = 1'b1; step(SETTLE);

        // R11: full sweep of the counter with the column strobe held low
        begin
            logic [ROW_BITS-1:0] first_row;
            first_row = mdl_ctr;
            n_ref = 0;
            cas_n = 1'b0; step(SETTLE);
            for (int k = 0; k < (1 << ROW_BITS); k++) begin
                ras_n = 1'b0; step(4);
                ras_n = 1'b1; step(4);
            end
            chk(n_ref == (1 << ROW_BITS), "R11 sweep refresh count", n_ref, 1 << ROW_BITS);
            ras_n = 1'b0; step(4);
            ras_n = 1'b1; step(4);
            chk(last_ref == first_row, "R11 wrap to first row", last_ref, first_row);
            cas_n = 1'b1; step(SETTLE);
            ctr_mode = 1'b0;
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule